// File: doc/BRIEF.md
# Two-by-two cell steering element

This block switches two synchronous streams of fixed-length cells onto two output streams. Both inputs share a single start-of-cell strobe. The first word of each cell is a header. When a cell begins, the element reads the two headers and chooses between two settings. In the straight setting each input keeps its own lane. In the swapped setting the two inputs trade lanes. That choice is stored in a register and held for every word of the cell.

The cell words pass through a short delay line. This lets the header word meet a setting that is already stable. A registered dual multiplexer then drives the two output lanes. Each output lane carries a valid bit, which copies the activity of the input routed to it. When two active cells ask for the same output, input 0 is served. The cell on input 1 is then sent to the free lane, and a deflection flag is raised for the whole cell.

The element is a leaf building block for larger fabrics. It keeps no buffers and does no table lookup.

Top module: `cell_steer2x2`

## Requirements
- R1: In the straight setting, out0 carries in0 and out1 carries in1. In the swapped setting, out0 carries in1 and out1 carries in0. The two lanes always carry different inputs.
- R2: Every input word appears on its output lane exactly two clock cycles after it is presented. This includes the header word.
- R3: The header is the input word sampled with an accepted start strobe. Bit 0 is the activity bit (1 = active). Bit 1 is the destination output (0 = out0, 1 = out1). No other word or bit affects routing.
- R4: If exactly one input is active, the setting delivers that cell to its requested output. An idle input's destination bit has no effect.
- R5: If both inputs are active and name the same output, input 0 goes to that output. Input 1 goes to the other output. That output's deflect flag is 1 on every word of the cell. The other deflect flag stays 0.
- R6: If both inputs are active and name different outputs, both cells reach their requested outputs and neither deflect flag is set.
- R7: If neither input is active, the straight setting is chosen and both valid bits stay 0 for the cell.
- R8: A cell lasts CELL_LEN words from its accepted strobe. A start strobe that arrives while a cell is in progress is ignored. The setting and the flags change only on an accepted strobe.
- R9: Each output valid bit equals the activity of the routed input during the CELL_LEN words of a cell, and is 0 outside cells. sop_out is 1 on the output cycle of each accepted header word.
- R10: While reset is asserted, every output is 0, and the setting returns to straight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sop_in | input | 1 | Start-of-cell strobe shared by both inputs |
| in0_word | input | DATA_W | Input lane 0 word |
| in1_word | input | DATA_W | Input lane 1 word |
| sop_out | output | 1 | Marks the header word on both output lanes |
| out0_word | output | DATA_W | Output lane 0 word |
| out0_valid | output | 1 | Output lane 0 carries an active cell word |
| out0_defl | output | 1 | Output lane 0 carries a deflected cell |
| out1_word | output | DATA_W | Output lane 1 word |
| out1_valid | output | 1 | Output lane 1 carries an active cell word |
| out1_defl | output | 1 | Output lane 1 carries a deflected cell |

## Verification
Every output — word, valid, deflect flag and sop_out — is due exactly two cycles after the input cycle that produced it. One register holds the decision together with the aligned word, and one register sits at the output. The bench drives inputs on the falling edge and predicts the result of each input cycle from its own model of the cell counter and the arbitration rule. It holds each prediction in a two-entry queue and compares it on the falling edge two cycles later. This way every header, every mid-cell strobe and every gap word is checked in the cycle where its effect becomes visible.

// File: rtl/xb2_pkg.sv
package xb2_pkg;

  typedef enum logic {
    XB_STRAIGHT = 1'b0,
    XB_SWAPPED  = 1'b1
  } xb_set_e;

  localparam int HDR_ACT_BIT = 0;
  localparam int HDR_DST_BIT = 1;

  typedef struct packed {
    logic act;
    logic dst;
  } hdr_t;

  typedef struct packed {
    xb_set_e setting;
    logic    defl;
  } verdict_t;

  // Pull activity and destination out of the two low header bits.
  function automatic hdr_t hdr_decode(input logic [1:0] low_bits);
    hdr_t h;
    h.act = low_bits[HDR_ACT_BIT];
    h.dst = low_bits[HDR_DST_BIT];
    return h;
  endfunction

  // Input 0 has priority. An idle input never steers the setting.
  function automatic verdict_t arbitrate(input hdr_t h0, input hdr_t h1);
    verdict_t v;
    v.setting = XB_STRAIGHT;
    v.defl    = 1'b0;
    if (h0.act) begin
      v.setting = h0.dst ? XB_SWAPPED : XB_STRAIGHT;
      v.defl    = h1.act && (h1.dst == h0.dst);
    end else if (h1.act) begin
      v.setting = h1.dst ? XB_STRAIGHT : XB_SWAPPED;
    end
    return v;
  endfunction

  // Index of the input routed to output lane 'lane'.
  function automatic logic lane_source(input logic lane, input xb_set_e s);
    return lane ^ s;
  endfunction

endpackage

// File: rtl/cell_framer.sv
module cell_framer #(
  parameter int CELL_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sop,
  output logic accept,
  output logic in_cell
);
  localparam int CW = (CELL_LEN > 1) ? $clog2(CELL_LEN) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(CELL_LEN - 1);

  logic [CW-1:0] words_left;
  logic          busy;

  assign busy    = (words_left != '0);
  assign accept  = sop && !busy;
  assign in_cell = accept || busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words_left <= '0;
    end else if (accept) begin
      words_left <= LAST_IDX;
    end else if (busy) begin
      words_left <= words_left - 1'b1;
    end
  end

  // R8: an accepted cell keeps the element busy for the rest of its words
  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (CELL_LEN > 1)) |=> busy);

endmodule

// File: rtl/route_decider.sv
module route_decider
  import xb2_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    accept,
  input  hdr_t    h0,
  input  hdr_t    h1,
  output xb_set_e setting_q,
  output logic    act0_q,
  output logic    act1_q,
  output logic    defl_q
);
  verdict_t verdict;

  assign verdict = arbitrate(h0, h1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setting_q <= XB_STRAIGHT;
      act0_q    <= 1'b0;
      act1_q    <= 1'b0;
      defl_q    <= 1'b0;
    end else if (accept) begin
      setting_q <= verdict.setting;
      act0_q    <= h0.act;
      act1_q    <= h1.act;
      defl_q    <= verdict.defl;
    end
  end

  // R5: on a clash input 0 gets its output and a deflection is recorded
  assert_in0_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && h0.act && h1.act && (h0.dst == h1.dst)) |=>
      (defl_q && (setting_q == ($past(h0.dst) ? XB_SWAPPED : XB_STRAIGHT))));

  // R4: an idle input 0 does not override an active input 1
  assert_idle_no_override_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !h0.act && h1.act) |=>
      (!defl_q && (setting_q == ($past(h1.dst) ? XB_STRAIGHT : XB_SWAPPED))));

  // R7: no activity means the straight setting
  assert_idle_straight_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !h0.act && !h1.act) |=> (setting_q == XB_STRAIGHT && !defl_q));

endmodule

// File: rtl/word_delay.sv
module word_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [DEPTH+1];

  assign stage[0] = din;

  for (genvar k = 0; k < DEPTH; k++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[k+1] <= '0;
      else        stage[k+1] <= stage[k];
    end
  end

  assign dout = stage[DEPTH];

endmodule

// File: rtl/cross_connect.sv
module cross_connect
  import xb2_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xb_set_e           setting,
  input  logic [1:0]        act,
  input  logic              defl,
  input  logic              live,
  input  logic              sop_d,
  input  logic [1:0][DATA_W-1:0] word_d,
  output logic              sop_q,
  output logic [1:0][DATA_W-1:0] word_q,
  output logic [1:0]        valid_q,
  output logic [1:0]        defl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sop_q <= 1'b0;
    else        sop_q <= sop_d;
  end

  for (genvar o = 0; o < 2; o++) begin : g_lane
    logic src;
    assign src = lane_source(1'(o), setting);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[o]  <= '0;
        valid_q[o] <= 1'b0;
        defl_q[o]  <= 1'b0;
      end else begin
        word_q[o]  <= word_d[src];
        valid_q[o] <= live && act[src];
        defl_q[o]  <= live && defl && src;
      end
    end
  end

  // R9: the output valid bits account for exactly the active routed inputs
  assert_valid_conserve_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(valid_q) == $past($countones(act & {2{live}}))));

  // R5: a deflection only shows while both lanes carry cells
  assert_defl_needs_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|defl_q) |-> (&valid_q));

  // R1: both lanes carry distinct inputs
  assert_lanes_distinct_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (word_d[0] != word_d[1]) |=> (word_q[0] != word_q[1]));

endmodule

// File: rtl/cell_steer2x2.sv
module cell_steer2x2
  import xb2_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CELL_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sop_in,
  input  logic [DATA_W-1:0] in0_word,
  input  logic [DATA_W-1:0] in1_word,
  output logic              sop_out,
  output logic [DATA_W-1:0] out0_word,
  output logic              out0_valid,
  output logic              out0_defl,
  output logic [DATA_W-1:0] out1_word,
  output logic              out1_valid,
  output logic              out1_defl
);
  // The decision takes one register, so the words are delayed by the same amount.
  localparam int DECIDE_LAT = 1;
  localparam int BUS_W      = 2 * DATA_W + 2;

  logic    accept;
  logic    in_cell;
  hdr_t    h0;
  hdr_t    h1;
  xb_set_e setting_q;
  logic    act0_q;
  logic    act1_q;
  logic    decide_defl;

  logic [BUS_W-1:0] bus_in;
  logic [BUS_W-1:0] bus_d;
  logic [1:0][DATA_W-1:0] word_d;
  logic             live_d;
  logic             sop_d;

  logic [1:0][DATA_W-1:0] word_q;
  logic [1:0]       valid_q;
  logic [1:0]       defl_q;

  cell_framer #(.CELL_LEN(CELL_LEN)) u_framer (
    .clk     (clk),
    .rst_n   (rst_n),
    .sop     (sop_in),
    .accept  (accept),
    .in_cell (in_cell)
  );

  assign h0 = hdr_decode(in0_word[1:0]);
  assign h1 = hdr_decode(in1_word[1:0]);

  route_decider u_decider (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .h0        (h0),
    .h1        (h1),
    .setting_q (setting_q),
    .act0_q    (act0_q),
    .act1_q    (act1_q),
    .defl_q    (decide_defl)
  );

  assign bus_in = {accept, in_cell, in1_word, in0_word};

  word_delay #(.W(BUS_W), .DEPTH(DECIDE_LAT)) u_align (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (bus_in),
    .dout  (bus_d)
  );

  assign word_d[0] = bus_d[DATA_W-1:0];
  assign word_d[1] = bus_d[2*DATA_W-1:DATA_W];
  assign live_d    = bus_d[2*DATA_W];
  assign sop_d     = bus_d[2*DATA_W+1];

  cross_connect #(.DATA_W(DATA_W)) u_xconn (
    .clk     (clk),
    .rst_n   (rst_n),
    .setting (setting_q),
    .act     ({act1_q, act0_q}),
    .defl    (decide_defl),
    .live    (live_d),
    .sop_d   (sop_d),
    .word_d  (word_d),
    .sop_q   (sop_out),
    .word_q  (word_q),
    .valid_q (valid_q),
    .defl_q  (defl_q)
  );

  assign out0_word  = word_q[0];
  assign out1_word  = word_q[1];
  assign out0_valid = valid_q[0];
  assign out1_valid = valid_q[1];
  assign out0_defl  = defl_q[0];
  assign out1_defl  = defl_q[1];

  // R8: the setting changes only after an accepted strobe
  assert_setting_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(setting_q));

  // R2: an accepted header reaches the outputs two cycles later
  assert_header_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ##2 sop_out);

  // R10: the outputs stay quiet while reset is held
  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R10: assert ({sop_out, out0_valid, out1_valid, out0_defl, out1_defl} == '0);
    end
  end

endmodule

// File: tb/cell_steer2x2_tb.sv
module cell_steer2x2_tb;
  localparam int W   = 16;
  localparam int LEN = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sop_in = 1'b0;
  logic [W-1:0] in0_word = '0;
  logic [W-1:0] in1_word = '0;
  logic         sop_out;
  logic [W-1:0] out0_word, out1_word;
  logic         out0_valid, out1_valid, out0_defl, out1_defl;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cell_steer2x2 #(.DATA_W(W), .CELL_LEN(LEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .sop_in(sop_in),
    .in0_word(in0_word), .in1_word(in1_word),
    .sop_out(sop_out),
    .out0_word(out0_word), .out0_valid(out0_valid), .out0_defl(out0_defl),
    .out1_word(out1_word), .out1_valid(out1_valid), .out1_defl(out1_defl)
  );

  typedef struct packed {
    logic         live;
    logic [W-1:0] o0;
    logic [W-1:0] o1;
    logic         v0, v1, f0, f1, s;
  } exp_t;

  exp_t  pipe0 = '0, pipe1 = '0;
  string tag0 = "", tag1 = "";

  // Bench model state
  int mcnt = 0;
  bit mswap = 0, ma0 = 0, ma1 = 0, mdef = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Which output each input wants, resolved with input 0 first.
  function automatic exp_t predict(input bit sop, input logic [W-1:0] a, input logic [W-1:0] b);
    exp_t e;
    bit acc, live;
    bit t0;
    acc = sop && (mcnt == 0);
    if (acc) begin
      ma0 = a[0]; ma1 = b[0]; mdef = 0;
      if (ma0) begin
        t0 = a[1];
        mdef = ma1 && (b[1] == a[1]);
      end else if (ma1) begin
        t0 = !b[1];
      end else begin
        t0 = 0;
      end
      mswap = t0;
      mcnt = LEN - 1;
      live = 1;
    end else if (mcnt > 0) begin
      mcnt--;
      live = 1;
    end else begin
      live = 0;
    end
    e.live = 1;
    e.o0 = mswap ? b : a;
    e.o1 = mswap ? a : b;
    e.v0 = live && (mswap ? ma1 : ma0);
    e.v1 = live && (mswap ? ma0 : ma1);
    e.f0 = live && mdef && mswap;
    e.f1 = live && mdef && !mswap;
    e.s  = acc;
    return e;
  endfunction

  task automatic compare_due();
    if (pipe1.live) begin
      check(out0_word == pipe1.o0, tag1, "out0_word", out0_word, pipe1.o0);
      check(out1_word == pipe1.o1, tag1, "out1_word", out1_word, pipe1.o1);
      check(out0_valid == pipe1.v0, tag1, "out0_valid R9", W'(out0_valid), W'(pipe1.v0));
      check(out1_valid == pipe1.v1, tag1, "out1_valid R9", W'(out1_valid), W'(pipe1.v1));
      check(out0_defl == pipe1.f0, tag1, "out0_defl", W'(out0_defl), W'(pipe1.f0));
      check(out1_defl == pipe1.f1, tag1, "out1_defl", W'(out1_defl), W'(pipe1.f1));
      check(sop_out == pipe1.s, tag1, "sop_out R9", W'(sop_out), W'(pipe1.s));
    end
  endtask

  // One input cycle: check what is due, then present new words.
  task automatic step(input bit s, input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    @(negedge clk);
    compare_due();
    pipe1 = pipe0; tag1 = tag0;
    sop_in = s; in0_word = a; in1_word = b;
    pipe0 = predict(s, a, b); tag0 = tag;
  endtask

  function automatic logic [W-1:0] rnd_word();
    return W'($urandom);
  endfunction

  // A whole cell; a non-negative mid places an extra strobe inside it.
  task automatic send_cell(input logic [1:0] hd0, input logic [1:0] hd1, input int mid, input string tag);
    for (int w = 0; w < LEN; w++) begin
      logic [W-1:0] a, b;
      a = rnd_word(); b = rnd_word();
      if (w == 0) begin
        a[1:0] = hd0; b[1:0] = hd1;
      end
      step((w == 0) || (w == mid), a, b, tag);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(1'b0, rnd_word(), rnd_word(), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_2024));
    // R10: reset state
    sop_in = 1; in0_word = 16'hFFFF; in1_word = 16'hFFFF;
    repeat (3) @(negedge clk);
    check({sop_out, out0_valid, out1_valid, out0_defl, out1_defl} == 5'b0, "R10", "flags in reset",
          W'({sop_out, out0_valid, out1_valid, out0_defl, out1_defl}), '0);
    check(out0_word == '0 && out1_word == '0, "R10", "words in reset", out0_word | out1_word, '0);
    sop_in = 0; in0_word = '0; in1_word = '0;
    rst_n = 1;

    idle(2, "R9");
    // Header bits: {dst, act}
    send_cell(2'b00, 2'b00, -1, "R7");
    send_cell(2'b11, 2'b00, -1, "R4");
    send_cell(2'b00, 2'b11, -1, "R4");
    send_cell(2'b10, 2'b01, -1, "R4");
    send_cell(2'b01, 2'b11, -1, "R4");
    send_cell(2'b01, 2'b11, -1, "R6");
    send_cell(2'b11, 2'b01, -1, "R1");
    send_cell(2'b01, 2'b01, -1, "R5");
    send_cell(2'b11, 2'b11, -1, "R5");
    send_cell(2'b11, 2'b11, 3, "R8");
    send_cell(2'b01, 2'b11, 1, "R8");
    idle(3, "R9");
    send_cell(2'b01, 2'b01, LEN - 1, "R8");
    send_cell(2'b11, 2'b01, -1, "R3");
    for (int c = 0; c < 300; c++) begin
      int mid;
      mid = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, LEN - 1)) : -1;
      send_cell(2'($urandom), 2'($urandom), mid, "R2");
      if ($urandom_range(0, 2) == 0) idle(int'($urandom_range(1, 3)), "R9");
    end
    idle(3, "R2");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule